// File: doc/BRIEF.md
# DMA Channel Address Generator with Start-Address Restore

This block produces the source and destination addresses of a single DMA channel. Each side has its own stepping mode: hold, count up or count down. The live address moves once per access strobe, by the beat width in bytes. Wrap-around is modulo 2^16.

A channel sequencer, which lies outside this block, drives the access strobe and three boundary strobes: end of burst, end of block and end of transaction. The generator keeps a stored copy of each start address. It copies that start address back into the live address at the boundary chosen for that side, or it never does so.

Start addresses are loaded only while the channel reports idle. A load writes both the stored copy and the live address. Data movement, request sequencing and arbitration are done elsewhere.

Top module: `dma_addr_gen`

## Requirements
- R1: While reset is high, and on the cycle after it falls, both live addresses read 0x0000 and both stored start copies are 0x0000.
- R2: A start write for a side (`*_start_we` high) while `chan_idle` is high loads that value into both the stored copy and the live address. The new value appears on the output after the next clock edge. This load takes precedence over any reload or step on the same cycle.
- R3: A start write while `chan_idle` is low has no effect. Neither the live address nor the stored copy changes, and a later reload restores the earlier start value.
- R4: Mode code 1 (count up): each cycle with `beat` high adds 2^`beat_size` to the live address. `beat_size` codes 0, 1, 2 and 3 mean 1, 2, 4 and 8 bytes.
- R5: Mode code 2 (count down): each cycle with `beat` high subtracts 2^`beat_size` from the live address.
- R6: Mode code 0 (hold), and the unused code 3, leave the live address unchanged on a beat.
- R7: Counting up past 0xFFFF or down past 0x0000 wraps modulo 2^16.
- R8: Reload point codes are 0 never, 1 burst, 2 block and 3 transaction. Point 1 fires on any of `burst_end`, `block_end` or `txn_end`. Point 2 fires on `block_end` or `txn_end`. Point 3 fires on `txn_end` only. When a point fires, the live address takes the stored start on the next edge.
- R9: When a reload fires on the same cycle as a beat, the reload wins and the step is dropped.
- R10: The source and destination sides follow their own mode and reload settings, independently of each other.
- R11: A cycle with no beat, no boundary strobe that fires the side's reload point, and no accepted start write leaves that side's live address unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chan_idle | input | 1 | Channel idle; start writes are accepted only while high |
| src_start_we | input | 1 | Source start address write strobe |
| src_start | input | 16 | Source start address value |
| dst_start_we | input | 1 | Destination start address write strobe |
| dst_start | input | 16 | Destination start address value |
| src_mode | input | 2 | Source step mode: 0 hold, 1 up, 2 down, 3 hold |
| dst_mode | input | 2 | Destination step mode, same encoding |
| src_reload | input | 2 | Source reload point: 0 never, 1 burst, 2 block, 3 transaction |
| dst_reload | input | 2 | Destination reload point, same encoding |
| beat_size | input | 2 | Beat width as log2 of bytes (0..3) |
| beat | input | 1 | One access completed this cycle |
| burst_end | input | 1 | Burst boundary strobe |
| block_end | input | 1 | Block boundary strobe |
| txn_end | input | 1 | Transaction boundary strobe |
| src_addr | output | 16 | Current source address |
| dst_addr | output | 16 | Current destination address |

## Verification
The hardest case to reach is a write refused while the channel is busy. Its only trace is in the stored copy, and the stored copy shows up at the ports only when a reload later fires. The directed part of the stimulus writes a start value while busy and then raises a transaction boundary. This checks that the older start comes back. Other directed cases are a reload on the same cycle as a beat, up and down wraps at 8-byte steps, and each strobe tried against each reload code. Random cycles with settings that change over time then mix beats, strobes and writes on both sides, with their settings different.

// File: rtl/dma_ag_pkg.sv
package dma_ag_pkg;

    localparam int AG_ADDR_W    = 16;
    localparam int AG_SIZE_W    = 2;
    localparam int AG_NUM_LANES = 2;
    localparam int AG_LANE_SRC  = 0;
    localparam int AG_LANE_DST  = 1;

    typedef enum logic [1:0] {
        STEP_HOLD = 2'd0,
        STEP_UP   = 2'd1,
        STEP_DOWN = 2'd2,
        STEP_RSVD = 2'd3
    } step_mode_e;

    typedef enum logic [1:0] {
        RLD_NEVER = 2'd0,
        RLD_BURST = 2'd1,
        RLD_BLOCK = 2'd2,
        RLD_TXN   = 2'd3
    } reload_pt_e;

    typedef struct packed {
        step_mode_e mode;
        reload_pt_e reload;
    } lane_cfg_t;

    typedef struct packed {
        logic burst;
        logic block;
        logic txn;
    } bound_t;

    // Whether a boundary set reaches the given reload point.
    // Wider boundaries also count as the narrower ones.
    function automatic logic point_hit(reload_pt_e pt, bound_t b);
        logic r;
        case (pt)
            RLD_BURST: r = b.burst | b.block | b.txn;
            RLD_BLOCK: r = b.block | b.txn;
            RLD_TXN:   r = b.txn;
            default:   r = 1'b0;
        endcase
        return r;
    endfunction

    // Map a raw mode code to the stepping direction: +1, -1 or 0.
    function automatic logic [1:0] dir_of(step_mode_e m);
        logic [1:0] d;
        case (m)
            STEP_UP:   d = 2'b01;
            STEP_DOWN: d = 2'b10;
            default:   d = 2'b00;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/dma_ag_bound.sv
module dma_ag_bound
    import dma_ag_pkg::*;
#(
    parameter int NUM_POINTS = 4
) (
    input  logic                  burst_end,
    input  logic                  block_end,
    input  logic                  txn_end,
    output logic [NUM_POINTS-1:0] hit
);
    bound_t b;
    assign b = '{burst: burst_end, block: block_end, txn: txn_end};

    for (genvar p = 0; p < NUM_POINTS; p++) begin : g_pt
        assign hit[p] = point_hit(reload_pt_e'(p), b);
    end
endmodule

// File: rtl/dma_ag_lane.sv
module dma_ag_lane
    import dma_ag_pkg::*;
#(
    parameter int ADDR_W = AG_ADDR_W,
    parameter int SIZE_W = AG_SIZE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_val,
    input  lane_cfg_t         cfg,
    input  logic [SIZE_W-1:0] beat_size,
    input  logic              beat,
    input  logic [3:0]        hit,
    output logic [ADDR_W-1:0] addr
);
    logic [ADDR_W-1:0] start_q, addr_q, step, addr_nxt;
    logic [1:0]        dir;
    logic              reload_fire;

    assign step        = ADDR_W'(1) << beat_size;
    assign dir         = dir_of(cfg.mode);
    assign reload_fire = hit[cfg.reload];

    always_comb begin
        addr_nxt = addr_q;
        if (load)             addr_nxt = load_val;
        else if (reload_fire) addr_nxt = start_q;
        else if (beat) begin
            case (dir)
                2'b01:   addr_nxt = addr_q + step;
                2'b10:   addr_nxt = addr_q - step;
                default: addr_nxt = addr_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            start_q <= '0;
            addr_q  <= '0;
        end else begin
            if (load) start_q <= load_val;
            addr_q <= addr_nxt;
        end
    end

    assign addr = addr_q;
endmodule

// File: rtl/dma_addr_gen.sv
module dma_addr_gen
    import dma_ag_pkg::*;
#(
    parameter int ADDR_W = AG_ADDR_W,
    parameter int SIZE_W = AG_SIZE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              chan_idle,
    input  logic              src_start_we,
    input  logic [ADDR_W-1:0] src_start,
    input  logic              dst_start_we,
    input  logic [ADDR_W-1:0] dst_start,
    input  logic [1:0]        src_mode,
    input  logic [1:0]        dst_mode,
    input  logic [1:0]        src_reload,
    input  logic [1:0]        dst_reload,
    input  logic [SIZE_W-1:0] beat_size,
    input  logic              beat,
    input  logic              burst_end,
    input  logic              block_end,
    input  logic              txn_end,
    output logic [ADDR_W-1:0] src_addr,
    output logic [ADDR_W-1:0] dst_addr
);
    localparam int NL = AG_NUM_LANES;

    logic [3:0]                  hit;
    logic [NL-1:0]               load_v;
    logic [NL-1:0][ADDR_W-1:0]   val_v;
    logic [NL-1:0][ADDR_W-1:0]   addr_v;
    lane_cfg_t                   cfg_v [NL];

    dma_ag_bound #(.NUM_POINTS(4)) u_bound (
        .burst_end (burst_end),
        .block_end (block_end),
        .txn_end   (txn_end),
        .hit       (hit)
    );

    assign load_v[AG_LANE_SRC] = src_start_we & chan_idle;
    assign load_v[AG_LANE_DST] = dst_start_we & chan_idle;
    assign val_v[AG_LANE_SRC]  = src_start;
    assign val_v[AG_LANE_DST]  = dst_start;
    assign cfg_v[AG_LANE_SRC]  = '{mode: step_mode_e'(src_mode), reload: reload_pt_e'(src_reload)};
    assign cfg_v[AG_LANE_DST]  = '{mode: step_mode_e'(dst_mode), reload: reload_pt_e'(dst_reload)};

    for (genvar g = 0; g < NL; g++) begin : g_lane
        dma_ag_lane #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) u_lane (
            .clk       (clk),
            .rst       (rst),
            .load      (load_v[g]),
            .load_val  (val_v[g]),
            .cfg       (cfg_v[g]),
            .beat_size (beat_size),
            .beat      (beat),
            .hit       (hit),
            .addr      (addr_v[g])
        );
    end

    assign src_addr = addr_v[AG_LANE_SRC];
    assign dst_addr = addr_v[AG_LANE_DST];
endmodule

// File: rtl/dma_addr_gen_chk.sv
module dma_addr_gen_chk #(
    parameter int ADDR_W = 16,
    parameter int SIZE_W = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              chan_idle,
    input logic              src_start_we,
    input logic [ADDR_W-1:0] src_start,
    input logic              dst_start_we,
    input logic [ADDR_W-1:0] dst_start,
    input logic [1:0]        src_mode,
    input logic [1:0]        dst_mode,
    input logic [1:0]        src_reload,
    input logic [1:0]        dst_reload,
    input logic [SIZE_W-1:0] beat_size,
    input logic              beat,
    input logic              burst_end,
    input logic              block_end,
    input logic              txn_end,
    input logic [ADDR_W-1:0] src_addr,
    input logic [ADDR_W-1:0] dst_addr
);
    logic [ADDR_W-1:0] step;
    logic [3:0]        pt;
    assign step  = ADDR_W'(1) << beat_size;
    assign pt[0] = 1'b0;
    assign pt[1] = burst_end | block_end | txn_end;
    assign pt[2] = block_end | txn_end;
    assign pt[3] = txn_end;

    logic [1:0]             we, acc, fire;
    logic [1:0][1:0]        md, rl;
    logic [1:0][ADDR_W-1:0] sv, ad, shadow;
    assign we = {dst_start_we, src_start_we};
    assign md = {dst_mode, src_mode};
    assign rl = {dst_reload, src_reload};
    assign sv = {dst_start, src_start};
    assign ad = {dst_addr, src_addr};

    for (genvar i = 0; i < 2; i++) begin : g_side
        assign acc[i]  = we[i] & chan_idle;
        assign fire[i] = pt[rl[i]];

        always_ff @(posedge clk) begin
            if (rst)         shadow[i] <= '0;
            else if (acc[i]) shadow[i] <= sv[i];
        end

        // R2: accepted write shows next cycle
        a_r2_load: assert property (@(posedge clk) disable iff (rst)
            acc[i] |=> ad[i] == $past(sv[i]));
        // R4: count up by beat width
        a_r4_up_step: assert property (@(posedge clk) disable iff (rst)
            (beat && !acc[i] && !fire[i] && md[i] == 2'd1) |=> ad[i] == $past(ad[i]) + $past(step));
        // R5: count down by beat width
        a_r5_down_step: assert property (@(posedge clk) disable iff (rst)
            (beat && !acc[i] && !fire[i] && md[i] == 2'd2) |=> ad[i] == $past(ad[i]) - $past(step));
        // R6: hold modes ignore beats
        a_r6_hold: assert property (@(posedge clk) disable iff (rst)
            (beat && !acc[i] && !fire[i] && (md[i] == 2'd0 || md[i] == 2'd3)) |=> $stable(ad[i]));
        // R8 / R9: reload restores the stored start, beat or not
        a_r9_reload_wins: assert property (@(posedge clk) disable iff (rst)
            (fire[i] && !acc[i]) |=> ad[i] == $past(shadow[i]));
        // R11: quiet cycle holds
        a_r11_quiet: assert property (@(posedge clk) disable iff (rst)
            (!beat && !fire[i] && !acc[i]) |=> $stable(ad[i]));
        // R3: busy write alone does nothing
        a_r3_busy_ignored: assert property (@(posedge clk) disable iff (rst)
            (we[i] && !chan_idle && !beat && !fire[i]) |=> $stable(ad[i]));
    end

    // R1: reset clears outputs
    a_r1_reset: assert property (@(posedge clk)
        rst |=> (src_addr == '0 && dst_addr == '0));
endmodule

bind dma_addr_gen dma_addr_gen_chk #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) u_chk (.*);

// File: tb/tb_dma_addr_gen.sv
module tb_dma_addr_gen;
    logic        clk = 1'b0;
    logic        rst;
    logic        chan_idle, src_start_we, dst_start_we;
    logic [15:0] src_start, dst_start;
    logic [1:0]  src_mode, dst_mode, src_reload, dst_reload, beat_size;
    logic        beat, burst_end, block_end, txn_end;
    logic [15:0] src_addr, dst_addr;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    logic [15:0] m_addr  [2];
    logic [15:0] m_start [2];

    always #5ns clk = ~clk;

    dma_addr_gen dut (.*);

    function automatic logic fires(logic [1:0] pt, logic bu, logic bl, logic tx);
        case (pt)
            2'd1:    return bu | bl | tx;
            2'd2:    return bl | tx;
            2'd3:    return tx;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic [15:0] stepped(logic [15:0] a, logic [1:0] m, logic [1:0] sz);
        int unsigned s = 1 << sz;
        if (m == 2'd1) return 16'((32'(a) + s) % 65536);
        if (m == 2'd2) return 16'((32'(a) + 65536 - s) % 65536);
        return a;
    endfunction

    function automatic string tag_for(int side);
        logic       w  = side ? dst_start_we : src_start_we;
        logic [1:0] m  = side ? dst_mode : src_mode;
        logic [1:0] rl = side ? dst_reload : src_reload;
        if (rst) return "R1";
        if (w && chan_idle) return "R2";
        if (fires(rl, burst_end, block_end, txn_end)) return beat ? "R9" : "R8";
        if (w) return "R3";
        if (beat) return (m == 2'd1) ? "R4" : (m == 2'd2) ? "R5" : "R6";
        return "R11";
    endfunction

    task automatic check(string tag, string what, logic [15:0] act, logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic drive_idle();
        src_start_we = 0; dst_start_we = 0; beat = 0;
        burst_end = 0; block_end = 0; txn_end = 0;
    endtask

    // One clock: update the model from the held inputs, then compare.
    task automatic tick(string force_tag = "");
        string t[2];
        @(posedge clk);
        for (int s = 0; s < 2; s++) begin
            logic       w  = s ? dst_start_we : src_start_we;
            logic [15:0] v = s ? dst_start : src_start;
            logic [1:0] m  = s ? dst_mode : src_mode;
            logic [1:0] rl = s ? dst_reload : src_reload;
            t[s] = (force_tag != "") ? force_tag : tag_for(s);
            if (rst) begin m_addr[s] = 0; m_start[s] = 0; end
            else if (w && chan_idle) begin m_addr[s] = v; m_start[s] = v; end
            else if (fires(rl, burst_end, block_end, txn_end)) m_addr[s] = m_start[s];
            else if (beat) m_addr[s] = stepped(m_addr[s], m, beat_size);
        end
        #1;
        check(t[0], "src_addr", src_addr, m_addr[0]);
        check(t[1], "dst_addr", dst_addr, m_addr[1]);
        @(negedge clk);
    endtask

    initial begin
        #1ms;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        m_addr[0] = 0; m_addr[1] = 0; m_start[0] = 0; m_start[1] = 0;
        rst = 1; chan_idle = 1; drive_idle();
        src_start = 0; dst_start = 0; src_mode = 0; dst_mode = 0;
        src_reload = 0; dst_reload = 0; beat_size = 0;
        @(negedge clk);
        tick("R1"); tick("R1");
        rst = 0;
        tick("R1");

        // R2 + R7: load near top, count up by 8 and wrap
        src_start = 16'hFFFC; src_start_we = 1; dst_start = 16'h0002; dst_start_we = 1;
        tick("R2");
        drive_idle(); chan_idle = 0;
        src_mode = 2'd1; dst_mode = 2'd2; beat_size = 2'd3; beat = 1;
        tick("R7");
        check("R7", "src wrap up", src_addr, 16'h0004);
        check("R7", "dst wrap down", dst_addr, 16'hFFFA);
        // R10: different settings per side
        beat_size = 2'd0; tick("R10");
        check("R10", "src up by 1", src_addr, 16'h0005);
        check("R10", "dst down by 1", dst_addr, 16'hFFF9);

        // R3: busy write ignored, then a transaction reload shows the old start
        drive_idle(); src_start = 16'h1234; src_start_we = 1;
        tick("R3");
        check("R3", "busy write live", src_addr, 16'h0005);
        drive_idle(); src_reload = 2'd3; dst_reload = 2'd0; txn_end = 1;
        tick("R3");
        check("R3", "stored copy kept", src_addr, 16'hFFFC);

        // R9: reload and beat together
        drive_idle(); beat = 1; tick();
        src_reload = 2'd1; burst_end = 1; beat = 1; tick("R9");
        check("R9", "reload beats step", src_addr, 16'hFFFC);

        // R8: each strobe against each reload code
        for (int code = 0; code < 4; code++) begin
            for (int sb = 0; sb < 3; sb++) begin
                drive_idle(); src_reload = 2'(code); beat = 1; tick();
                drive_idle(); src_reload = 2'(code);
                burst_end = (sb == 0); block_end = (sb == 1); txn_end = (sb == 2);
                tick("R8");
            end
        end

        // Random mix
        for (int c = 0; c < 4000; c++) begin
            if (c % 64 == 0) begin
                src_mode = 2'($urandom); dst_mode = 2'($urandom);
                src_reload = 2'($urandom); dst_reload = 2'($urandom);
                beat_size = 2'($urandom);
            end
            chan_idle    = ($urandom % 6) == 0;
            src_start_we = ($urandom % 12) == 0;
            dst_start_we = ($urandom % 12) == 0;
            src_start    = 16'($urandom); dst_start = 16'($urandom);
            beat         = ($urandom % 2) == 0;
            burst_end    = ($urandom % 6) == 0;
            block_end    = ($urandom % 14) == 0;
            txn_end      = ($urandom % 30) == 0;
            tick();
        end
        drive_idle(); tick("R11");

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule